// File: doc/BRIEF.md
# MSB Weight Mismatch Code Corrector

This block is a digital clean-up stage that sits after a successive-approximation converter. The top capacitors of such a converter are never exactly twice their neighbours, so the raw 12-bit code is biased whenever one of the upper bits is set. The block keeps one signed trim coefficient for each of the four upper bits. For every accepted sample it adds an error term built from those coefficients to the raw code, and it returns the result as a wider signed fixed-point value.

The weight of an upper bit at position p is treated as 2^(p-1)·(2+Δp), so setting that bit adds 2^(p-1)·Δp to the ideal value. Bits 7..0 keep their binary weights and add nothing. The coefficients are found elsewhere, for example by spectral analysis of a test tone, and are written in through a small indexed load port. The datapath is a two-stage pipeline with a fixed latency.

Top module: `msb_trim_corrector`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid is 0 and out_code is 0. Reset also clears all four coefficients to zero.
- R2: out_valid is high exactly two clock cycles after a cycle in which in_valid was high, and it is low in every other cycle.
- R3: With all coefficients at zero, out_code equals in_code·256, which is the raw code with 8 zero fraction bits appended.
- R4: When in_code[11:8] is 0, out_code equals in_code·256 whatever the coefficient values are.
- R5: Coefficients are two's-complement coef_data words with 8 fraction bits, so value = word/256. out_code is a two's-complement value with 8 fraction bits and equals in_code·256 + Σ word_p·2^(p-1), summed over the set bits p of 8..11. A clear bit adds nothing.
- R6: A coef_idx value k selects the coefficient of bit 8+k: 0→bit 8, 1→bit 9, 2→bit 10, 3→bit 11.
- R7: A coefficient write (coef_we high at a clock edge) affects only samples accepted at later edges. A sample accepted at the same edge as the write, or one already in flight, uses the previous value.
- R8: When the exact result is above 2^21−1 or below −2^21, out_code saturates to 2^21−1 or −2^21.
- R9: out_code holds its value in every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Raw sample qualifier |
| in_code | input | 12 | Raw converter code, unsigned |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 2 | Coefficient slot, k maps to bit 8+k |
| coef_data | input | 12 | Signed coefficient, 8 fraction bits |
| out_valid | output | 1 | Corrected sample qualifier |
| out_code | output | 22 | Corrected code, signed, 8 fraction bits |

## Verification
Codes with an all-zero upper nibble are run against random coefficient sets. A wrong result there shows that lower bits are being corrected or that the ideal value is built incorrectly. Single upper-bit codes against a single loaded slot show whether each index is wired to its intended bit. Writes that coincide with a sample, or that follow one still in flight, show whether the coefficients are captured at the right edge. Extreme coefficients with all upper bits set drive both saturation limits. Long random runs with idle gaps then mix every bit pattern with the latency and hold rules.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  // Ceiling log2, with a floor of 1 so that index ports never collapse to zero width.
  function automatic int clog2c(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    if (r < 1) r = 1;
    return r;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mtc_coef_bank.sv
module mtc_coef_bank #(
  parameter int NCORR  = 4,
  parameter int COEF_W = 12,
  parameter int IDX_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [COEF_W-1:0]             wr_data,
  output logic [NCORR-1:0][COEF_W-1:0]  coefs
);

  // Every slot is read in parallel each cycle, so the slots are plain registers.
  for (genvar k = 0; k < NCORR; k++) begin : g_slot
    logic [COEF_W-1:0] slot_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(k))) begin
        slot_q <= wr_data;
      end
    end

    assign coefs[k] = slot_q;
  end

endmodule

// File: rtl/mtc_term_stage.sv
module mtc_term_stage #(
  parameter int DATA_W = 12,
  parameter int NCORR  = 4,
  parameter int COEF_W = 12,
  parameter int TERM_W = 22
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [DATA_W-1:0]             in_code,
  input  logic [NCORR-1:0][COEF_W-1:0]  coefs,
  output logic                          s1_valid,
  output logic [DATA_W-1:0]             s1_raw,
  output logic [NCORR-1:0][TERM_W-1:0]  s1_terms
);

  localparam int LOW_BITS = DATA_W - NCORR;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_raw   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_raw <= in_code;
    end
  end

  // One error term per trimmed bit: coefficient scaled by 2^(p-1) when bit p is set.
  for (genvar k = 0; k < NCORR; k++) begin : g_term
    localparam int BITP  = LOW_BITS + k;
    localparam int SHIFT = BITP - 1;

    logic [TERM_W-1:0] ext_w;
    logic [TERM_W-1:0] term_d;
    logic [TERM_W-1:0] term_q;

    assign ext_w  = {{(TERM_W-COEF_W){coefs[k][COEF_W-1]}}, coefs[k]};
    assign term_d = in_code[BITP] ? (ext_w << SHIFT) : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        term_q <= '0;
      end else if (in_valid) begin
        term_q <= term_d;
      end
    end

    assign s1_terms[k] = term_q;
  end

endmodule

// File: rtl/mtc_sum_stage.sv
module mtc_sum_stage #(
  parameter int DATA_W = 12,
  parameter int NCORR  = 4,
  parameter int FRAC_W = 8,
  parameter int TERM_W = 22,
  parameter int SUM_W  = 26,
  parameter int OUT_W  = 22
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          s1_valid,
  input  logic [DATA_W-1:0]             s1_raw,
  input  logic [NCORR-1:0][TERM_W-1:0]  s1_terms,
  output logic                          out_valid,
  output logic [OUT_W-1:0]              out_code
);

  localparam logic signed [SUM_W-1:0] POS_LIM =
    SUM_W'((longint'(1) <<< (OUT_W-1)) - longint'(1));
  localparam logic signed [SUM_W-1:0] NEG_LIM = ~POS_LIM;

  logic signed [SUM_W-1:0] acc;
  logic        [OUT_W-1:0] sat_w;

  always_comb begin
    acc = $signed({{(SUM_W-DATA_W-FRAC_W){1'b0}}, s1_raw, {FRAC_W{1'b0}}});
    for (int k = 0; k < NCORR; k++) begin
      acc = acc + $signed({{(SUM_W-TERM_W){s1_terms[k][TERM_W-1]}}, s1_terms[k]});
    end
  end

  always_comb begin
    if (acc > POS_LIM) begin
      sat_w = POS_LIM[OUT_W-1:0];
    end else if (acc < NEG_LIM) begin
      sat_w = NEG_LIM[OUT_W-1:0];
    end else begin
      sat_w = acc[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_code <= sat_w;
    end
  end

endmodule

// File: rtl/msb_trim_corrector.sv
module msb_trim_corrector
  import mtc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NCORR  = 4,
  parameter int COEF_W = 12,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 22
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  input  logic [DATA_W-1:0]                in_code,
  input  logic                             coef_we,
  input  logic [clog2c(NCORR)-1:0]         coef_idx,
  input  logic [COEF_W-1:0]                coef_data,
  output logic                             out_valid,
  output logic [OUT_W-1:0]                 out_code
);

  localparam int IDX_W  = clog2c(NCORR);
  localparam int TERM_W = COEF_W + DATA_W - 2;
  localparam int SUM_W  = max2(TERM_W, DATA_W + FRAC_W + 1) + clog2c(NCORR + 1) + 1;

  logic [NCORR-1:0][COEF_W-1:0] coefs;
  logic                         s1_valid;
  logic [DATA_W-1:0]            s1_raw;
  logic [NCORR-1:0][TERM_W-1:0] s1_terms;

  mtc_coef_bank #(
    .NCORR (NCORR),
    .COEF_W(COEF_W),
    .IDX_W (IDX_W)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (coef_we),
    .wr_idx (coef_idx),
    .wr_data(coef_data),
    .coefs  (coefs)
  );

  mtc_term_stage #(
    .DATA_W(DATA_W),
    .NCORR (NCORR),
    .COEF_W(COEF_W),
    .TERM_W(TERM_W)
  ) u_terms (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_code (in_code),
    .coefs   (coefs),
    .s1_valid(s1_valid),
    .s1_raw  (s1_raw),
    .s1_terms(s1_terms)
  );

  mtc_sum_stage #(
    .DATA_W(DATA_W),
    .NCORR (NCORR),
    .FRAC_W(FRAC_W),
    .TERM_W(TERM_W),
    .SUM_W (SUM_W),
    .OUT_W (OUT_W)
  ) u_sum (
    .clk      (clk),
    .rst      (rst),
    .s1_valid (s1_valid),
    .s1_raw   (s1_raw),
    .s1_terms (s1_terms),
    .out_valid(out_valid),
    .out_code (out_code)
  );

endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
  parameter int DATA_W = 12,
  parameter int NCORR  = 4,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_code,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_code
);

  // Cycles since reset, saturating, so that $past never reaches before reset.
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && (out_code == '0)));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R4
  low_bits_ideal_chk: assert property (@(posedge clk) disable iff (rst)
    ((age_q >= 2'd2) && out_valid &&
     ($past(in_code[DATA_W-1:DATA_W-NCORR], 2) == '0))
    |-> (out_code == {{(OUT_W-DATA_W-FRAC_W){1'b0}}, $past(in_code, 2), {FRAC_W{1'b0}}}));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((age_q >= 2'd1) && !out_valid) |-> $stable(out_code));

endmodule

bind msb_trim_corrector mtc_checker #(
  .DATA_W(DATA_W),
  .NCORR (NCORR),
  .FRAC_W(FRAC_W),
  .OUT_W (OUT_W)
) u_mtc_checker (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_code  (in_code),
  .out_valid(out_valid),
  .out_code (out_code)
);

// File: tb/msb_trim_corrector_test.sv
module msb_trim_corrector_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 12;
  localparam int NCORR  = 4;
  localparam int COEF_W = 12;
  localparam int FRAC_W = 8;
  localparam int OUT_W  = 22;
  localparam int IDX_W  = 2;
  localparam longint POS_LIM = (longint'(1) <<< (OUT_W-1)) - 1;
  localparam longint NEG_LIM = -(longint'(1) <<< (OUT_W-1));

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst;
  logic              in_valid;
  logic [DATA_W-1:0] in_code;
  logic              coef_we;
  logic [IDX_W-1:0]  coef_idx;
  logic [COEF_W-1:0] coef_data;
  logic              out_valid;
  logic [OUT_W-1:0]  out_code;

  msb_trim_corrector uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
    .out_valid(out_valid), .out_code(out_code)
  );

  int     checks = 0;
  int     fails  = 0;
  bit     done   = 0;
  int     shadow [NCORR];
  bit     prev_v = 0;
  longint prev_e = 0;
  string  prev_tag = "";
  longint last_out = 0;

  function automatic int sx(input int d);
    return (d <<< (32-COEF_W)) >>> (32-COEF_W);
  endfunction

  function automatic longint exact_val(input logic [DATA_W-1:0] c);
    longint acc;
    acc = longint'(c) * (longint'(1) <<< FRAC_W);
    for (int k = 0; k < NCORR; k++) begin
      if (c[DATA_W-NCORR+k]) acc += longint'(shadow[k]) <<< (DATA_W-NCORR+k-1);
    end
    return acc;
  endfunction

  function automatic longint clip(input longint x);
    if (x > POS_LIM) return POS_LIM;
    if (x < NEG_LIM) return NEG_LIM;
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, then check the sample driven one step earlier.
  task automatic step(input bit v, input logic [DATA_W-1:0] code, input bit we,
                      input int idx, input int data, input string tag_in);
    longint pre, e, act;
    string  tag;
    in_valid  = v;
    in_code   = code;
    coef_we   = we;
    coef_idx  = idx[IDX_W-1:0];
    coef_data = data[COEF_W-1:0];
    pre = exact_val(code);
    e   = clip(pre);
    tag = tag_in;
    if (tag == "") begin
      if (code[DATA_W-1:DATA_W-NCORR] == '0) tag = "R4";
      else if (pre != e) tag = "R8";
      else tag = "R5";
    end
    if (we) shadow[idx] = sx(data);
    @(posedge clk);
    @(negedge clk);
    act = longint'($signed(out_code));
    if (prev_v) begin
      chk(out_valid === 1'b1, "R2", longint'(out_valid), 1);
      chk(act == prev_e, prev_tag, act, prev_e);
    end else begin
      chk(out_valid === 1'b0, "R2", longint'(out_valid), 0);
      chk(act == last_out, "R9", act, last_out);
    end
    last_out = act;
    prev_v   = v;
    prev_e   = e;
    prev_tag = tag;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int k = 0; k < NCORR; k++) shadow[k] = 0;
    rst = 1'b1; in_valid = 1'b0; in_code = '0;
    coef_we = 1'b0; coef_idx = '0; coef_data = '0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs under reset, even with a sample offered
    in_valid = 1'b1; in_code = 12'hFFF;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", longint'(out_valid), 0);
    chk(out_code == '0, "R1", longint'($signed(out_code)), 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", longint'(out_valid), 0);
    chk(out_code == '0, "R1", longint'($signed(out_code)), 0);

    // R3: cleared coefficients give the plain scaled code (also confirms R1 clearing)
    step(1, 12'hFFF, 0, 0, 0, "R3");
    step(1, 12'h000, 0, 0, 0, "R3");
    step(1, 12'hA5C, 0, 0, 0, "R3");
    step(1, 12'h801, 0, 0, 0, "R3");

    // R6: each slot drives only its own bit
    for (int k = 0; k < NCORR; k++) begin
      step(0, '0, 1, k, 256, "");
      step(1, DATA_W'(1) << (8 + k), 0, 0, 0, "R6");
      step(1, DATA_W'(1) << (8 + ((k + 1) % NCORR)), 0, 0, 0, "R6");
      step(0, '0, 1, k, 0, "");
    end

    // R7: write in the same cycle as a sample, then one while a sample is in flight
    step(1, 12'h800, 1, 3, 100, "R7");
    step(1, 12'h800, 0, 0, 0, "R7");
    step(1, 12'h8FF, 0, 0, 0, "R7");
    step(0, '0, 1, 3, -50, "");
    step(1, 12'h800, 0, 0, 0, "R7");

    // R4: random coefficients, upper nibble clear
    for (int k = 0; k < NCORR; k++) step(0, '0, 1, k, int'($urandom % 4096), "");
    for (int n = 0; n < 20; n++) step(1, DATA_W'($urandom % 256), 0, 0, 0, "R4");

    // R8: both saturation limits
    for (int k = 0; k < NCORR; k++) step(0, '0, 1, k, 2047, "");
    step(1, 12'hFFF, 0, 0, 0, "R8");
    for (int k = 0; k < NCORR; k++) step(0, '0, 1, k, 2048, "");
    step(1, 12'hF00, 0, 0, 0, "R8");
    step(1, 12'h0FF, 0, 0, 0, "R4");

    // R5 and R2/R9: random mix of samples, gaps and writes
    for (int n = 0; n < 600; n++) begin
      step(($urandom % 4) != 0, DATA_W'($urandom), ($urandom % 8) == 0,
           int'($urandom % NCORR), int'($urandom % 4096), "");
    end
    step(0, '0, 0, 0, 0, "");
    step(0, '0, 0, 0, 0, "");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule